// File: doc/BRIEF.md
# Four-State Instruction Scheduling Queue

This block is a fixed-capacity scheduling buffer for an out-of-order core. Every slot holds one dispatched instruction and steps it through four stages: waiting (some operand latency is still unknown), pending (every latency is known but the instruction cannot start yet), ready (all operands available and no memory dependency outstanding) and issued (executing until write-back). The dispatch stage first asks the status output whether it may dispatch, then writes the instruction into the lowest free slot. Wakeup, memory-dependency clear, issue grant and write-back each name a slot.

Stage changes are registered. A waiting entry becomes pending on the clock edge after all of its latencies are known. A pending entry becomes ready on the edge after all of its operands are available and its memory dependency is clear. Ready entries are offered to an external picker. Zero-latency instructions that are ready are offered ahead of all others, so they never sit behind older work. The picker's grant moves the entry to issued. Write-back releases the slot.

Top module: `sched_queue`

## Requirements
- R1: After reset every slot is invalid, `wait_empty` and `ready_empty` are 1, `dsp_status` is 0 (available) and `free_slot` is 0.
- R2: A slot dispatched at a clock edge is valid after that edge, in stage encoding 2'b10 (ready) if every `disp_avail` bit is 1 and `disp_memdep` is 0, otherwise 2'b01 (pending) if every operand is available or latency-known, otherwise 2'b00 (waiting). Each slot's stage sits in `ent_state[2*i+1:2*i]`.
- R3: A waiting entry moves to pending on the edge after every operand's latency is known. Operand availability counts as a known latency. A waiting entry never moves straight to ready.
- R4: A pending entry moves to ready (2'b10) on the edge after all operands are available and its memory dependency has been cleared. Until then it stays pending.
- R5: A grant on a slot whose `offer_mask` bit is 1 moves that entry to issued (2'b11) at the edge. A grant on any other slot changes nothing.
- R6: `urgent_mask` marks ready entries that carry the zero-latency flag. While any such bit is set, `offer_mask` equals `urgent_mask`. Otherwise `offer_mask` marks every ready entry.
- R7: Write-back on an issued entry clears its valid bit at the edge, so the slot is free in the following cycle. Write-back on an entry that is not issued is ignored.
- R8: Dispatch onto a slot that is valid at the edge, even one being written back in the same cycle, leaves that slot unchanged and raises `disp_err` for exactly the following cycle.
- R9: `dsp_status` uses a fixed priority and these encodings: 3 (buffers full) when no slot is free; else 1 (load queue full) if `qry_load` and `lq_full`; else 2 (store queue full) if `qry_store` and `sq_full`; else 4 (dispatch group stall) if `grp_stall`; else 0. `free_slot` is the lowest invalid slot index.
- R10: `wait_empty` is 1 exactly when no valid entry is waiting. `ready_empty` is 1 exactly when no valid entry is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qry_load | input | 1 | Queried instruction is a load |
| qry_store | input | 1 | Queried instruction is a store |
| lq_full | input | 1 | Load queue has no room |
| sq_full | input | 1 | Store queue has no room |
| grp_stall | input | 1 | Dispatch group must stall |
| dsp_status | output | 3 | Stall reason for the current query |
| free_slot | output | IW | Lowest free slot |
| disp_valid | input | 1 | Dispatch strobe |
| disp_slot | input | IW | Target slot |
| disp_avail | input | NOPS | Operand available flags |
| disp_latk | input | NOPS | Operand latency-known flags |
| disp_memdep | input | 1 | Memory dependency outstanding |
| disp_zlat | input | 1 | Zero-latency instruction |
| disp_err | output | 1 | Dispatch hit a valid slot last cycle |
| wk_valid | input | 1 | Wakeup strobe |
| wk_slot | input | IW | Wakeup target slot |
| wk_op | input | OW | Wakeup operand index |
| wk_avail | input | 1 | Operand now available |
| wk_latk | input | 1 | Operand latency now known |
| md_clr_valid | input | 1 | Memory dependency clear strobe |
| md_clr_slot | input | IW | Slot whose dependency clears |
| offer_mask | output | DEPTH | Slots the picker may grant |
| urgent_mask | output | DEPTH | Ready zero-latency slots |
| iss_valid | input | 1 | Picker grant strobe |
| iss_slot | input | IW | Granted slot |
| wb_valid | input | 1 | Write-back strobe |
| wb_slot | input | IW | Completing slot |
| ent_valid | output | DEPTH | Per-slot valid bits |
| ent_state | output | 2*DEPTH | Per-slot stage, 2 bits each |
| wait_empty | output | 1 | No waiting entry |
| ready_empty | output | 1 | No ready entry |

## Verification
The hardest case to reach from the ports is a waiting entry whose operands all become available while it still waits. It must pass through pending for one cycle instead of jumping to ready. The bench dispatches an entry with no operand information and wakes its operands as available one per cycle. It then checks the stage on each following edge. A second hard case is a dispatch that collides with a write-back to the same slot in the same cycle. The bench builds it by issuing an entry and then driving both strobes together.

// File: rtl/sq_pkg.sv
package sq_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'b00,
      ST_PEND = 2'b01,
      ST_RDY  = 2'b10,
      ST_ISS  = 2'b11
   } ent_stage_t;

   typedef enum logic [2:0] {
      DS_OK  = 3'd0,
      DS_LQ  = 3'd1,
      DS_SQ  = 3'd2,
      DS_BUF = 3'd3,
      DS_GRP = 3'd4
   } disp_stat_t;

endpackage

// File: rtl/sq_entry.sv
module sq_entry
   import sq_pkg::*;
#(
   parameter int NOPS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            disp_hit,
   input  logic [NOPS-1:0] d_avail,
   input  logic [NOPS-1:0] d_latk,
   input  logic            d_md,
   input  logic            d_zl,
   input  logic [NOPS-1:0] av_set,
   input  logic [NOPS-1:0] lk_set,
   input  logic            md_clr,
   input  logic            iss_hit,
   input  logic            wb_hit,
   output logic            valid_o,
   output ent_stage_t      stage_o,
   output logic            zl_o
);

   logic [NOPS-1:0] avail_q, latk_q;
   logic            md_q, zl_q, v_q;
   ent_stage_t      st_q, init_st;

   always_comb begin
      if ((&d_avail) && !d_md)     init_st = ST_RDY;
      else if (&(d_latk | d_avail)) init_st = ST_PEND;
      else                          init_st = ST_WAIT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q     <= 1'b0;
         st_q    <= ST_WAIT;
         avail_q <= '0;
         latk_q  <= '0;
         md_q    <= 1'b0;
         zl_q    <= 1'b0;
      end else if (disp_hit && !v_q) begin
         v_q     <= 1'b1;
         st_q    <= init_st;
         avail_q <= d_avail;
         latk_q  <= d_latk | d_avail;
         md_q    <= d_md;
         zl_q    <= d_zl;
      end else if (v_q) begin
         avail_q <= avail_q | av_set;
         latk_q  <= latk_q | lk_set | av_set;
         if (md_clr) md_q <= 1'b0;
         unique case (st_q)
            ST_WAIT: if (&latk_q) st_q <= ST_PEND;
            ST_PEND: if ((&avail_q) && !md_q) st_q <= ST_RDY;
            ST_RDY:  if (iss_hit) st_q <= ST_ISS;
            ST_ISS:  if (wb_hit) v_q <= 1'b0;
            default: st_q <= ST_WAIT;
         endcase
      end
   end

   assign valid_o = v_q;
   assign stage_o = st_q;
   assign zl_o    = zl_q;

   // R3
   wait_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && st_q == ST_WAIT) |=> (st_q != ST_RDY));

   // R5
   iss_from_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && st_q != ST_RDY && st_q != ST_ISS) |=> (st_q != ST_ISS));

   // R4
   rdy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && st_q == ST_RDY && !iss_hit) |=> (v_q && st_q == ST_RDY));

   // R7
   wb_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && st_q == ST_ISS && wb_hit) |=> !v_q);

endmodule

// File: rtl/sq_offer.sv
module sq_offer #(
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] rdy_i,
   input  logic [DEPTH-1:0] zl_i,
   output logic [DEPTH-1:0] offer_o,
   output logic [DEPTH-1:0] urgent_o
);

   assign urgent_o = rdy_i & zl_i;
   assign offer_o  = (|urgent_o) ? urgent_o : rdy_i;

   // R5
   offer_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((offer_o & ~rdy_i) == '0));

   // R6
   urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rdy_i & zl_i)) |-> ((offer_o & ~zl_i) == '0));

endmodule

// File: rtl/sq_stat.sv
module sq_stat
   import sq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] valid_i,
   input  logic             qry_load,
   input  logic             qry_store,
   input  logic             lq_full,
   input  logic             sq_full,
   input  logic             grp_stall,
   output disp_stat_t       status_o,
   output logic [IW-1:0]    free_o
);

   always_comb begin
      free_o = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!valid_i[i]) free_o = IW'(i);
   end

   always_comb begin
      if (&valid_i)                   status_o = DS_BUF;
      else if (qry_load && lq_full)   status_o = DS_LQ;
      else if (qry_store && sq_full)  status_o = DS_SQ;
      else if (grp_stall)             status_o = DS_GRP;
      else                            status_o = DS_OK;
   end

   // R9
   full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&valid_i) |-> (status_o == DS_BUF));

   // R9
   free_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o != DS_BUF) |-> !valid_i[free_o]);

endmodule

// File: rtl/sched_queue.sv
module sched_queue
   import sq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int NOPS  = 3,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int OW   = (NOPS > 1) ? $clog2(NOPS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               qry_load,
   input  logic               qry_store,
   input  logic               lq_full,
   input  logic               sq_full,
   input  logic               grp_stall,
   output logic [2:0]         dsp_status,
   output logic [IW-1:0]      free_slot,
   input  logic               disp_valid,
   input  logic [IW-1:0]      disp_slot,
   input  logic [NOPS-1:0]    disp_avail,
   input  logic [NOPS-1:0]    disp_latk,
   input  logic               disp_memdep,
   input  logic               disp_zlat,
   output logic               disp_err,
   input  logic               wk_valid,
   input  logic [IW-1:0]      wk_slot,
   input  logic [OW-1:0]      wk_op,
   input  logic               wk_avail,
   input  logic               wk_latk,
   input  logic               md_clr_valid,
   input  logic [IW-1:0]      md_clr_slot,
   output logic [DEPTH-1:0]   offer_mask,
   output logic [DEPTH-1:0]   urgent_mask,
   input  logic               iss_valid,
   input  logic [IW-1:0]      iss_slot,
   input  logic               wb_valid,
   input  logic [IW-1:0]      wb_slot,
   output logic [DEPTH-1:0]   ent_valid,
   output logic [2*DEPTH-1:0] ent_state,
   output logic               wait_empty,
   output logic               ready_empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sched_queue: DEPTH must be at least 2");
   end
   if (NOPS < 1) begin : g_bad_nops
      $error("sched_queue: NOPS must be at least 1");
   end

   logic [DEPTH-1:0] disp_hit, iss_hit, wb_hit, md_hit, zl_vec, rdy_vec, wait_vec;
   logic [NOPS-1:0]  av_set [DEPTH];
   logic [NOPS-1:0]  lk_set [DEPTH];
   ent_stage_t       stage  [DEPTH];
   disp_stat_t       stat;
   logic             err_q;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         disp_hit[i] = disp_valid && (disp_slot == IW'(i)) && !ent_valid[i];
         iss_hit[i]  = iss_valid && (iss_slot == IW'(i)) && offer_mask[i];
         wb_hit[i]   = wb_valid && (wb_slot == IW'(i));
         md_hit[i]   = md_clr_valid && (md_clr_slot == IW'(i));
         for (int o = 0; o < NOPS; o++) begin
            av_set[i][o] = wk_valid && wk_avail && (wk_slot == IW'(i)) && (wk_op == OW'(o));
            lk_set[i][o] = wk_valid && wk_latk && (wk_slot == IW'(i)) && (wk_op == OW'(o));
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      sq_entry #(.NOPS(NOPS)) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .disp_hit(disp_hit[g]),
         .d_avail (disp_avail),
         .d_latk  (disp_latk),
         .d_md    (disp_memdep),
         .d_zl    (disp_zlat),
         .av_set  (av_set[g]),
         .lk_set  (lk_set[g]),
         .md_clr  (md_hit[g]),
         .iss_hit (iss_hit[g]),
         .wb_hit  (wb_hit[g]),
         .valid_o (ent_valid[g]),
         .stage_o (stage[g]),
         .zl_o    (zl_vec[g])
      );
      assign ent_state[2*g +: 2] = stage[g];
      assign rdy_vec[g]  = ent_valid[g] && (stage[g] == ST_RDY);
      assign wait_vec[g] = ent_valid[g] && (stage[g] == ST_WAIT);
   end

   sq_offer #(.DEPTH(DEPTH)) u_offer (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_i   (rdy_vec),
      .zl_i    (zl_vec),
      .offer_o (offer_mask),
      .urgent_o(urgent_mask)
   );

   sq_stat #(.DEPTH(DEPTH), .IW(IW)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (ent_valid),
      .qry_load (qry_load),
      .qry_store(qry_store),
      .lq_full  (lq_full),
      .sq_full  (sq_full),
      .grp_stall(grp_stall),
      .status_o (stat),
      .free_o   (free_slot)
   );

   assign dsp_status  = stat;
   assign wait_empty  = ~|wait_vec;
   assign ready_empty = ~|rdy_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= disp_valid && ent_valid[disp_slot];
   end
   assign disp_err = err_q;

   // R8
   collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && ent_valid[disp_slot]) |=> disp_err);

   // R2
   disp_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !ent_valid[disp_slot]) |=> ent_valid[$past(disp_slot)]);

endmodule

// File: tb/sched_queue_test.sv
module sched_queue_test;

   localparam int DEPTH = 4;
   localparam int NOPS  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic qry_load = 0, qry_store = 0, lq_full = 0, sq_full = 0, grp_stall = 0;
   logic [2:0] dsp_status;
   logic [1:0] free_slot;
   logic disp_valid = 0;
   logic [1:0] disp_slot = 0;
   logic [1:0] disp_avail = 0, disp_latk = 0;
   logic disp_memdep = 0, disp_zlat = 0, disp_err;
   logic wk_valid = 0;
   logic [1:0] wk_slot = 0;
   logic [0:0] wk_op = 0;
   logic wk_avail = 0, wk_latk = 0;
   logic md_clr_valid = 0;
   logic [1:0] md_clr_slot = 0;
   logic [3:0] offer_mask, urgent_mask, ent_valid;
   logic iss_valid = 0;
   logic [1:0] iss_slot = 0;
   logic wb_valid = 0;
   logic [1:0] wb_slot = 0;
   logic [7:0] ent_state;
   logic wait_empty, ready_empty;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sched_queue #(.DEPTH(DEPTH), .NOPS(NOPS)) uut (
      .clk(clk), .rst_n(rst_n), .qry_load(qry_load), .qry_store(qry_store),
      .lq_full(lq_full), .sq_full(sq_full), .grp_stall(grp_stall),
      .dsp_status(dsp_status), .free_slot(free_slot), .disp_valid(disp_valid),
      .disp_slot(disp_slot), .disp_avail(disp_avail), .disp_latk(disp_latk),
      .disp_memdep(disp_memdep), .disp_zlat(disp_zlat), .disp_err(disp_err),
      .wk_valid(wk_valid), .wk_slot(wk_slot), .wk_op(wk_op), .wk_avail(wk_avail),
      .wk_latk(wk_latk), .md_clr_valid(md_clr_valid), .md_clr_slot(md_clr_slot),
      .offer_mask(offer_mask), .urgent_mask(urgent_mask), .iss_valid(iss_valid),
      .iss_slot(iss_slot), .wb_valid(wb_valid), .wb_slot(wb_slot),
      .ent_valid(ent_valid), .ent_state(ent_state), .wait_empty(wait_empty),
      .ready_empty(ready_empty)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int stg(input int i);
      return int'(ent_state[2*i +: 2]);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic disp(input int s, input int av, input int lk, input bit md, input bit zl);
      disp_valid = 1; disp_slot = 2'(s); disp_avail = 2'(av); disp_latk = 2'(lk);
      disp_memdep = md; disp_zlat = zl;
      tick();
      disp_valid = 0;
   endtask

   task automatic wake(input int s, input int op, input bit av, input bit lk);
      wk_valid = 1; wk_slot = 2'(s); wk_op = 1'(op); wk_avail = av; wk_latk = lk;
      tick();
      wk_valid = 0;
   endtask

   task automatic grant(input int s);
      iss_valid = 1; iss_slot = 2'(s);
      tick();
      iss_valid = 0;
   endtask

   task automatic wback(input int s);
      wb_valid = 1; wb_slot = 2'(s);
      tick();
      wb_valid = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 valid", int'(ent_valid), 0);
      chk("R1 wait_empty", int'(wait_empty), 1);
      chk("R1 ready_empty", int'(ready_empty), 1);
      chk("R1 status", int'(dsp_status), 0);
      chk("R1 free_slot", int'(free_slot), 0);
   endtask

   task automatic t_kinds();
      do_reset();
      disp(0, 3, 0, 0, 0);
      disp(1, 1, 2, 0, 0);
      disp(2, 0, 1, 0, 0);
      disp(3, 3, 0, 1, 0);
      chk("R2 valid", int'(ent_valid), 15);
      chk("R2 ready", stg(0), 2);
      chk("R2 pending mixed", stg(1), 1);
      chk("R2 waiting", stg(2), 0);
      chk("R2 pending memdep", stg(3), 1);
      chk("R10 wait_empty", int'(wait_empty), 0);
      chk("R10 ready_empty", int'(ready_empty), 0);
      qry_load = 1; lq_full = 1; #1;
      chk("R9 full wins", int'(dsp_status), 3);
      qry_load = 0; lq_full = 0;
   endtask

   task automatic t_wait();
      do_reset();
      disp(1, 0, 0, 0, 0);
      chk("R2 waiting dispatch", stg(1), 0);
      wake(1, 0, 1, 0);
      chk("R3 still waiting", stg(1), 0);
      wake(1, 1, 1, 0);
      chk("R3 waiting at edge of last wake", stg(1), 0);
      tick();
      chk("R3 pending not ready", stg(1), 1);
      chk("R10 wait_empty", int'(wait_empty), 1);
      tick();
      chk("R4 ready after pending", stg(1), 2);
      chk("R10 ready_empty", int'(ready_empty), 0);
      disp(2, 0, 0, 0, 0);
      wake(2, 0, 0, 1);
      wake(2, 1, 0, 1);
      tick();
      chk("R3 latency-only pending", stg(2), 1);
      tick();
      chk("R4 pending stays without operands", stg(2), 1);
   endtask

   task automatic t_memdep();
      do_reset();
      disp(0, 3, 0, 1, 0);
      tick();
      chk("R4 pending on memdep", stg(0), 1);
      md_clr_valid = 1; md_clr_slot = 0;
      tick();
      md_clr_valid = 0;
      chk("R4 pending at clear edge", stg(0), 1);
      tick();
      chk("R4 ready after clear", stg(0), 2);
      disp(1, 2, 1, 0, 0);
      chk("R2 pending by latency", stg(1), 1);
      wake(1, 0, 1, 0);
      chk("R4 pending at wake edge", stg(1), 1);
      tick();
      chk("R4 ready after wake", stg(1), 2);
   endtask

   task automatic t_issue_wb();
      chk("R5 offer two ready", int'(offer_mask), 3);
      grant(2);
      chk("R5 grant on empty slot ignored", int'(ent_valid), 3);
      chk("R5 slot0 unchanged", stg(0), 2);
      grant(0);
      chk("R5 issued", stg(0), 3);
      chk("R5 offer after issue", int'(offer_mask), 2);
      wback(1);
      chk("R7 wb on ready ignored valid", int'(ent_valid[1]), 1);
      chk("R7 wb on ready ignored stage", stg(1), 2);
      wback(0);
      chk("R7 freed", int'(ent_valid), 2);
      chk("R9 free_slot after wb", int'(free_slot), 0);
      grant(1);
      chk("R5 slot1 issued", stg(1), 3);
      wb_valid = 1; wb_slot = 1;
      disp_valid = 1; disp_slot = 1; disp_avail = 3; disp_latk = 0;
      disp_memdep = 0; disp_zlat = 0;
      tick();
      wb_valid = 0; disp_valid = 0;
      chk("R7 freed same cycle", int'(ent_valid[1]), 0);
      chk("R8 error on wb collision", int'(disp_err), 1);
      tick();
      chk("R8 error one cycle", int'(disp_err), 0);
   endtask

   task automatic t_zlat();
      do_reset();
      disp(0, 3, 0, 0, 0);
      disp(1, 3, 0, 0, 1);
      chk("R6 urgent", int'(urgent_mask), 2);
      chk("R6 offer urgent only", int'(offer_mask), 2);
      grant(0);
      chk("R6 older grant ignored", stg(0), 2);
      grant(1);
      chk("R6 urgent issued", stg(1), 3);
      chk("R6 offer falls back", int'(offer_mask), 1);
      chk("R6 urgent clear", int'(urgent_mask), 0);
   endtask

   task automatic t_collide();
      do_reset();
      disp(2, 0, 0, 0, 0);
      disp(2, 3, 0, 0, 0);
      chk("R8 error flag", int'(disp_err), 1);
      chk("R8 stage unchanged", stg(2), 0);
      tick();
      chk("R8 stage still waiting", stg(2), 0);
      chk("R8 error cleared", int'(disp_err), 0);
   endtask

   task automatic t_status();
      do_reset();
      disp(0, 0, 0, 0, 0);
      chk("R9 free lowest", int'(free_slot), 1);
      qry_load = 1; lq_full = 1; #1;
      chk("R9 load full", int'(dsp_status), 1);
      qry_store = 1; sq_full = 1; #1;
      chk("R9 load beats store", int'(dsp_status), 1);
      qry_load = 0; #1;
      chk("R9 store full", int'(dsp_status), 2);
      qry_store = 0; grp_stall = 1; #1;
      chk("R9 group stall", int'(dsp_status), 4);
      grp_stall = 0; #1;
      chk("R9 full flags without query", int'(dsp_status), 0);
      lq_full = 0; sq_full = 0;
      disp(2, 0, 0, 0, 0);
      chk("R9 free skips hole", int'(free_slot), 1);
      disp(1, 0, 0, 0, 0);
      chk("R9 free last", int'(free_slot), 3);
      disp(3, 0, 0, 0, 0);
      chk("R9 buffers full", int'(dsp_status), 3);
   endtask

   initial begin
      t_reset();
      t_kinds();
      t_wait();
      t_memdep();
      t_issue_wb();
      t_zlat();
      t_collide();
      t_status();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule